// File: doc/BRIEF.md
# Frequency-Change Watchdog with Reset Pulse

This block is a supervisory countdown timer that guards a clock-frequency change. Software arms it by setting the enable input and then changing the frequency. Each frequency-change strobe seen while enable is high loads the counter and starts the countdown. If software does not drop the enable before the count runs out, the block raises a one-cycle time-out event and sets a sticky status flag. It can also drive an active-low system reset pulse.

Time is measured in base ticks, a strobe input that stands in for the millisecond time base. A prescaler groups the ticks into units. One selection gives a short unit and the other gives a long unit, and each unit length is a parameter given in ticks. A 5-bit timeout field value of k counts k+1 units, so the field gives 1 to 32 units.

The reset output can be triggered in two ways, each with its own enable: a time-out, and every frequency-change strobe. The output is a plain active-low signal, and an external open-drain driver is assumed.

Top module: `wdt_supervisor`

## Requirements
- R1: After reset, `sys_rst_n_o` is 1, `timeout_o` is 0 and `sts_o` is 0.
- R2: With `wd_en_i`=1, a `freq_chg_i` strobe arms the timer. Ticks are counted from the cycle after the strobe. `timeout_o` goes to 1 in the cycle after the tick that completes (k+1)*U ticks, where k is `tmo_val_i` and U is SHORT_TICKS when `long_unit_i`=0 or LONG_TICKS when `long_unit_i`=1.
- R3: While `wd_en_i`=0 the counter is stopped and reloaded. Dropping the enable during a countdown cancels it, so no time-out follows.
- R4: Neither a `freq_chg_i` strobe with `wd_en_i`=0 nor a later rise of `wd_en_i` starts the countdown.
- R5: `sts_o` becomes 1 together with `timeout_o`. It stays 1 until a status write (`sts_wr_i`=1) with `sts_wdata_i`=1. A status write with `sts_wdata_i`=0 leaves it unchanged. The flag clears in the cycle after the write.
- R6: When `rst_on_tmo_i`=1, `sys_rst_n_o` is 0 for exactly RST_PULSE_CYC cycles, starting in the same cycle that `timeout_o` is 1. When `rst_on_tmo_i`=0, a time-out produces no pulse.
- R7: When `rst_on_fchg_i`=1, every `freq_chg_i` strobe drives `sys_rst_n_o` to 0 for RST_PULSE_CYC cycles, starting the cycle after the strobe. This happens whatever the value of `wd_en_i`.
- R8: A new trigger during a reset pulse restarts the full pulse width.
- R9: `timeout_o` lasts one cycle. After a time-out the timer stays idle, with no further time-out, until another strobe arrives with `wd_en_i`=1.
- R10: A strobe during a running countdown reloads it, so a full (k+1)*U ticks are needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Base time tick strobe |
| tmo_val_i | input | TMO_W | Timeout field k; the timeout is k+1 units |
| long_unit_i | input | 1 | Unit select: 0 selects the short unit, 1 selects the long unit |
| wd_en_i | input | 1 | Watchdog enable; 0 stops and reloads the counter |
| rst_on_tmo_i | input | 1 | Enables a reset pulse on time-out |
| rst_on_fchg_i | input | 1 | Enables a reset pulse on each frequency change |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 1 | Status write data; 1 clears the flag |
| freq_chg_i | input | 1 | Frequency-change strobe |
| timeout_o | output | 1 | One-cycle time-out event |
| sts_o | output | 1 | Sticky time-out status |
| sys_rst_n_o | output | 1 | Active-low system reset pulse |

## Verification
The bench builds the block with SHORT_TICKS=3, LONG_TICKS=5 and RST_PULSE_CYC=4. With these values even the all-ones field, at 160 ticks, ends in a few hundred cycles, so both unit selections and the full range of field values can be exercised. Ticks arrive on random cycles, which exercises the prescaler holding its count between ticks. The short pulse width puts the retrigger case, where a second strobe lands two cycles into a pulse, within easy reach.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // number of units loaded for a timeout field value
  function automatic int unsigned units_for_field(input int unsigned field);
    return field + 1;
  endfunction

  // ticks per unit for the selected prescale
  function automatic int unsigned ticks_per_unit(input logic long_sel,
                                                 input int unsigned short_t,
                                                 input int unsigned long_t);
    return long_sel ? long_t : short_t;
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned SHORT_TICKS = 150,
  parameter int unsigned LONG_TICKS  = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  input  logic tick_i,
  input  logic long_sel_i,
  output logic unit_o
);
  localparam int unsigned MAXU = (SHORT_TICKS > LONG_TICKS) ? SHORT_TICKS : LONG_TICKS;
  localparam int unsigned PS_W = $clog2(MAXU + 1);

  logic [PS_W-1:0] pcnt;
  logic [PS_W-1:0] last;

  assign last   = PS_W'(wdt_pkg::ticks_per_unit(long_sel_i, SHORT_TICKS, LONG_TICKS) - 1);
  assign unit_o = run_i && !clear_i && tick_i && (pcnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (clear_i || !run_i) begin
      pcnt <= '0;
    end else if (tick_i) begin
      if (pcnt >= last) pcnt <= '0;
      else              pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned TMO_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             arm_i,
  input  logic             unit_i,
  input  logic [TMO_W-1:0] tmo_val_i,
  output logic             running_o,
  output logic             expire_o
);
  localparam int unsigned CNT_W = TMO_W + 1;

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(wdt_pkg::units_for_field(32'(tmo_val_i)));
  assign expire_o = en_i && !arm_i && running_o && unit_i && (remain == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_o <= 1'b0;
      remain    <= '0;
    end else if (!en_i) begin
      running_o <= 1'b0;
      remain    <= load_val;
    end else if (arm_i) begin
      running_o <= 1'b1;
      remain    <= load_val;
    end else if (running_o && unit_i) begin
      if (remain <= CNT_W'(1)) begin
        running_o <= 1'b0;
        remain    <= '0;
      end else begin
        remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int unsigned RST_PULSE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger_i,
  output logic rst_n_o
);
  localparam int unsigned PW_W = $clog2(RST_PULSE_CYC + 1);

  logic [PW_W-1:0] left;

  assign rst_n_o = (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left <= '0;
    else if (trigger_i)      left <= PW_W'(RST_PULSE_CYC);
    else if (left != '0)     left <= left - 1'b1;
  end
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
  parameter int unsigned TMO_W         = 5,
  parameter int unsigned SHORT_TICKS   = 150,
  parameter int unsigned LONG_TICKS    = 2500,
  parameter int unsigned RST_PULSE_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [TMO_W-1:0] tmo_val_i,
  input  logic             long_unit_i,
  input  logic             wd_en_i,
  input  logic             rst_on_tmo_i,
  input  logic             rst_on_fchg_i,
  input  logic             sts_wr_i,
  input  logic             sts_wdata_i,
  input  logic             freq_chg_i,
  output logic             timeout_o,
  output logic             sts_o,
  output logic             sys_rst_n_o
);
  // internal events, named for the checker
  logic arm_w;
  logic unit_w;
  logic running_w;
  logic expire_w;
  logic trigger_w;

  assign arm_w     = freq_chg_i && wd_en_i;
  assign trigger_w = (expire_w && rst_on_tmo_i) || (freq_chg_i && rst_on_fchg_i);

  wdt_prescaler #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (arm_w),
    .run_i      (running_w),
    .tick_i     (tick_i),
    .long_sel_i (long_unit_i),
    .unit_o     (unit_w)
  );

  wdt_countdown #(.TMO_W(TMO_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (wd_en_i),
    .arm_i     (arm_w),
    .unit_i    (unit_w),
    .tmo_val_i (tmo_val_i),
    .running_o (running_w),
    .expire_o  (expire_w)
  );

  wdt_rst_pulse #(.RST_PULSE_CYC(RST_PULSE_CYC)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .trigger_i (trigger_w),
    .rst_n_o   (sys_rst_n_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeout_o <= 1'b0;
      sts_o     <= 1'b0;
    end else begin
      timeout_o <= expire_w;
      if (expire_w)                    sts_o <= 1'b1;
      else if (sts_wr_i && sts_wdata_i) sts_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic wd_en_i,
  input logic rst_on_tmo_i,
  input logic rst_on_fchg_i,
  input logic freq_chg_i,
  input logic sts_wr_i,
  input logic sts_wdata_i,
  input logic expire_w,
  input logic running_w,
  input logic timeout_o,
  input logic sts_o,
  input logic sys_rst_n_o
);
  a_r5_sts_set: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |=> (sts_o && timeout_o));

  a_r5_sts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_o && !(sts_wr_i && sts_wdata_i)) |=> sts_o);

  a_r9_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  a_r9_idle_no_expire: assert property (@(posedge clk) disable iff (!rst_n)
    !running_w |-> !expire_w);

  a_r6_pulse_on_tmo: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && rst_on_tmo_i) |=> !sys_rst_n_o);

  a_r7_pulse_on_fchg: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_chg_i && rst_on_fchg_i) |=> !sys_rst_n_o);

  a_r3_disabled_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en_i |=> !running_w);
endmodule

bind wdt_supervisor wdt_supervisor_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wd_en_i       (wd_en_i),
  .rst_on_tmo_i  (rst_on_tmo_i),
  .rst_on_fchg_i (rst_on_fchg_i),
  .freq_chg_i    (freq_chg_i),
  .sts_wr_i      (sts_wr_i),
  .sts_wdata_i   (sts_wdata_i),
  .expire_w      (expire_w),
  .running_w     (running_w),
  .timeout_o     (timeout_o),
  .sts_o         (sts_o),
  .sys_rst_n_o   (sys_rst_n_o)
);

// File: tb/wdt_supervisor_tb.sv
module wdt_supervisor_tb;
  localparam int SHT = 3;
  localparam int LNG = 5;
  localparam int PW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic [4:0] tmo_val_i = 5'd0;
  logic long_unit_i = 1'b0;
  logic wd_en_i = 1'b0;
  logic rst_on_tmo_i = 1'b0;
  logic rst_on_fchg_i = 1'b0;
  logic sts_wr_i = 1'b0;
  logic sts_wdata_i = 1'b0;
  logic freq_chg_i = 1'b0;
  logic timeout_o, sts_o, sys_rst_n_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  wdt_supervisor #(.TMO_W(5), .SHORT_TICKS(SHT), .LONG_TICKS(LNG), .RST_PULSE_CYC(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .tmo_val_i(tmo_val_i),
    .long_unit_i(long_unit_i), .wd_en_i(wd_en_i), .rst_on_tmo_i(rst_on_tmo_i),
    .rst_on_fchg_i(rst_on_fchg_i), .sts_wr_i(sts_wr_i), .sts_wdata_i(sts_wdata_i),
    .freq_chg_i(freq_chg_i), .timeout_o(timeout_o), .sts_o(sts_o), .sys_rst_n_o(sys_rst_n_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual cyc=%0d expected <100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic int want_ticks(input int field, input bit lng);
    int per;
    per = lng ? LNG : SHT;
    return per * field + per;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe_fchg();
    @(negedge clk); freq_chg_i = 1'b1; tick_i = 1'b0;
    @(negedge clk); freq_chg_i = 1'b0;
  endtask

  // drive n ticks on random cycles; check no early timeout and the final state
  task automatic give_ticks(input int n, input bit exp_tmo, input string req);
    int got = 0;
    int early = 0;
    while (got < n) begin
      bit t;
      t = ($urandom_range(0, 2) != 0);
      tick_i = t;
      @(negedge clk);
      if (t) got++;
      if (got < n && timeout_o) early++;
    end
    tick_i = 1'b0;
    check(early == 0, req, early, 0);
    check(timeout_o == exp_tmo, req, timeout_o, exp_tmo);
  endtask

  // count consecutive low cycles of the reset output from the current negedge
  task automatic low_width(output int w);
    w = 0;
    while (!sys_rst_n_o && w < 100) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic clear_sts();
    @(negedge clk); sts_wr_i = 1'b1; sts_wdata_i = 1'b1;
    @(negedge clk); sts_wr_i = 1'b0; sts_wdata_i = 1'b0;
  endtask

  initial begin
    int w;
    void'($urandom(32'h5eed));
    #1;
    check(sys_rst_n_o == 1 && timeout_o == 0 && sts_o == 0, "R1 reset", {sys_rst_n_o, timeout_o, sts_o}, 3'b100);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sys_rst_n_o == 1 && timeout_o == 0 && sts_o == 0, "R1 after reset", {sys_rst_n_o, timeout_o, sts_o}, 3'b100);

    // R2 directed corners: field 0 and all ones, both units
    wd_en_i = 1'b1;
    for (int c = 0; c < 4; c++) begin
      tmo_val_i   = (c % 2 == 0) ? 5'd0 : 5'd31;
      long_unit_i = (c >= 2);
      strobe_fchg();
      give_ticks(want_ticks(tmo_val_i, long_unit_i), 1'b1, "R2 corner");
      @(negedge clk);
      check(timeout_o == 0, "R9 one cycle", timeout_o, 0);
    end

    // R5 status sticky, write 0 ignored, write 1 clears
    check(sts_o == 1, "R5 set", sts_o, 1);
    @(negedge clk); sts_wr_i = 1'b1; sts_wdata_i = 1'b0;
    @(negedge clk); sts_wr_i = 1'b0;
    check(sts_o == 1, "R5 write0 ignored", sts_o, 1);
    clear_sts();
    check(sts_o == 0, "R5 write1 clears", sts_o, 0);

    // R9 idle after time-out
    give_ticks(200, 1'b0, "R9 no rearm");
    check(sts_o == 0, "R9 no status", sts_o, 0);

    // R2 random field and unit
    for (int i = 0; i < 8; i++) begin
      tmo_val_i   = 5'($urandom_range(0, 31));
      long_unit_i = 1'($urandom_range(0, 1));
      strobe_fchg();
      give_ticks(want_ticks(tmo_val_i, long_unit_i), 1'b1, "R2 random");
    end
    clear_sts();

    // R3 enable drop cancels and reloads
    tmo_val_i = 5'd3; long_unit_i = 1'b0;
    strobe_fchg();
    give_ticks(want_ticks(3, 0) - 2, 1'b0, "R3 partial");
    @(negedge clk); wd_en_i = 1'b0;
    @(negedge clk); wd_en_i = 1'b1;
    give_ticks(60, 1'b0, "R3 cancelled");
    check(sts_o == 0, "R3 no status", sts_o, 0);
    strobe_fchg();
    give_ticks(want_ticks(3, 0), 1'b1, "R3 full reload");
    clear_sts();

    // R4 strobe with enable low, then enable rise
    wd_en_i = 1'b0;
    strobe_fchg();
    @(negedge clk); wd_en_i = 1'b1;
    give_ticks(80, 1'b0, "R4 no start");

    // R10 restrike during countdown
    tmo_val_i = 5'd2; long_unit_i = 1'b1;
    strobe_fchg();
    give_ticks(want_ticks(2, 1) - 3, 1'b0, "R10 before");
    strobe_fchg();
    give_ticks(want_ticks(2, 1) - 1, 1'b0, "R10 reloaded");
    give_ticks(1, 1'b1, "R10 final tick");
    clear_sts();

    // R6 pulse on time-out, and none when disabled
    rst_on_tmo_i = 1'b1; tmo_val_i = 5'd1; long_unit_i = 1'b0;
    strobe_fchg();
    give_ticks(want_ticks(1, 0), 1'b1, "R6 tmo");
    low_width(w);
    check(w == PW, "R6 width", w, PW);
    rst_on_tmo_i = 1'b0;
    strobe_fchg();
    give_ticks(want_ticks(1, 0), 1'b1, "R6 tmo2");
    check(sys_rst_n_o == 1, "R6 disabled", sys_rst_n_o, 1);
    clear_sts();

    // R7 pulse on frequency change, enable low
    rst_on_fchg_i = 1'b1; wd_en_i = 1'b0;
    strobe_fchg();
    low_width(w);
    check(w == PW, "R7 width", w, PW);

    // R8 retrigger two cycles into the pulse
    strobe_fchg();
    @(negedge clk); freq_chg_i = 1'b1;
    @(negedge clk); freq_chg_i = 1'b0;
    low_width(w);
    check(w == PW, "R8 restart", w, PW);
    rst_on_fchg_i = 1'b0;
    strobe_fchg();
    check(sys_rst_n_o == 1, "R7 disabled", sys_rst_n_o, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule